// File: doc/BRIEF.md
# DSP Core Power-Up Boot Sequencer

This block takes an embedded DSP core from full reset to executing code after a single start pulse. It first releases the subsystem resets and sets the global configuration fields. It then latches the boot vector and turns on the crystal clock branch. After that it walks the core power-control word through a fixed series of settings, powering the head switch, the regulator bypass, the clamps and the memory retention controls. Between those settings it switches on the memory banks one at a time, starting from the highest-numbered bank.

When the power ramp is complete, it takes the core out of reset in two phases, with the core clock enabled in between. It then waits for the core to signal a handover.

Waits in the sequence are timed in two ways. Short settling waits count clock cycles (`CYC_PER_US` per microsecond). Millisecond waits count pulses on the `ms_tick` input, so a system timebase or a testbench can set their pace. When the sequence finishes, `done` or `timeout` is raised. The current step number is always visible on `step`.

Top module: `dsp_boot_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start, the outputs hold their idle values: `subsys_rst`=1, `core_blk_rst`=1, `glb_cfg0`=0, `glb_cfg1_b0`=1, `vec_base`=0, `xo_en`=0, `pwr_word`=0, `mem_bank_en`=0, `core_rst_ctl`=3'h1, `dbg_keep`=1, `clk_mux`=0, `hs_warn`=0, `done`=0, `timeout`=0, `step`=0.
- R2: A start pulse is accepted only when `step`=0. A start at any other time, including after the sequence has finished, leaves `step` and every output unchanged. The finished states persist until reset.
- R3: The first four steps run in this order, one per cycle. Both resets drop to 0. Then `glb_cfg0` becomes 0x14 and `glb_cfg1_b0` becomes 0. Then `vec_base` takes `boot_addr[31:4]`. Then `xo_en` becomes 1.
- R4: Next, `pwr_word` becomes 0x1700000 and holds for `CYC_PER_US` settling cycles before polling begins. When `hs_status` is already 1, the value is held for exactly `CYC_PER_US`+1 cycles.
- R5: Polling moves on in the first cycle `hs_status` is 1. If `HS_RETRIES` ms ticks pass without it, `hs_warn` is set and the sequence continues anyway.
- R6: After 0x1700000, `pwr_word` takes exactly these values in this order: 0x3700000, 0x3300000, 0x33C0000, then (after the bank phase) 0x31FFFFF and 0x30FFFFF.
- R7: Memory banks are switched on one bit per step, from bit `BANKS`-1 down to bit 0. Bits once set stay set. Each bank, including the last, is held for `BANK_DWELL_MS` ms ticks before the next change.
- R8: Core release: `core_rst_ctl` goes to 0x5 with `dbg_keep` cleared to 0 in the same step. Then `clk_mux` becomes 0x102. Then `core_rst_ctl` becomes 0x4.
- R9: During the handover wait (`step`=15), a rising edge on `handover` raises `done` on the next clock edge and moves to `step`=16. A `handover` level that was already high before the wait does not count.
- R10: If `HANDOVER_MS` ms ticks pass in the wait with no rising edge, `timeout` rises on the tick that completes the count and `step` becomes 17. `done` and `timeout` are never both 1.
- R11: `step` encodes the phase: 0 idle, 6 head-switch polling, 10 bank phase, 15 handover wait, 16 running, 17 failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request pulse |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| hs_status | input | 1 | Head-switch ready status |
| handover | input | 1 | Core handover signal (rising edge counts) |
| boot_addr | input | 32 | Boot address |
| subsys_rst | output | 1 | Subsystem reset (1 = asserted) |
| core_blk_rst | output | 1 | Core block reset (1 = asserted) |
| glb_cfg0 | output | 5 | Global config field |
| glb_cfg1_b0 | output | 1 | Second config word, bit 0 |
| vec_base | output | 28 | Reset vector (boot address >> 4) |
| xo_en | output | 1 | Crystal clock branch enable |
| pwr_word | output | 32 | Core power-control word |
| mem_bank_en | output | 20 | Memory bank switch enables |
| core_rst_ctl | output | 3 | Core reset control value |
| dbg_keep | output | 1 | Debug config value |
| clk_mux | output | 10 | Core clock mux control |
| hs_warn | output | 1 | Head-switch poll timed out |
| done | output | 1 | Handover received, core running |
| timeout | output | 1 | Handover wait expired |
| step | output | 5 | Current sequence step |

## Verification
The properties assume `start`, `ms_tick`, `hs_status` and `handover` are synchronous to `clk`. They also assume `ms_tick` is a single-cycle pulse and `boot_addr` is stable from start until the vector is latched. The stimulus changes every input only on the falling clock edge. It gives `ms_tick` one high cycle in every three, and holds `boot_addr` fixed for a whole run. The bench covers three head-switch behaviours: status ready at once, status arriving late, and status never arriving. It also covers a handover that arrives, one that never arrives, and one that was already high before the wait began.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE  = 5'd0,
        ST_RST   = 5'd1,
        ST_CFG   = 5'd2,
        ST_VEC   = 5'd3,
        ST_XO    = 5'd4,
        ST_HS    = 5'd5,
        ST_POLL  = 5'd6,
        ST_BYP   = 5'd7,
        ST_CLAMP = 5'd8,
        ST_SLEEP = 5'd9,
        ST_BANK  = 5'd10,
        ST_WL    = 5'd11,
        ST_IO    = 5'd12,
        ST_HOLD  = 5'd13,
        ST_CLK   = 5'd14,
        ST_HO    = 5'd15,
        ST_RUN   = 5'd16,
        ST_FAIL  = 5'd17
    } seq_state_e;

    localparam int PWR_W     = 32;
    localparam int CFG_W     = 5;
    localparam int MUX_W     = 10;
    localparam int CORE_W    = 3;
    localparam int VEC_SHIFT = 4;

    localparam logic [PWR_W-1:0] PW_HS_ON  = 32'h0170_0000;
    localparam logic [PWR_W-1:0] PW_BYPASS = 32'h0370_0000;
    localparam logic [PWR_W-1:0] PW_CLAMP  = 32'h0330_0000;
    localparam logic [PWR_W-1:0] PW_SLEEP  = 32'h033C_0000;
    localparam logic [PWR_W-1:0] PW_WLINE  = 32'h031F_FFFF;
    localparam logic [PWR_W-1:0] PW_IO     = 32'h030F_FFFF;

    localparam logic [CFG_W-1:0]  CFG0_VAL   = 5'h14;
    localparam logic [CORE_W-1:0] CORE_RESET = 3'h1;
    localparam logic [CORE_W-1:0] CORE_HOLD  = 3'h5;
    localparam logic [CORE_W-1:0] CORE_GO    = 3'h4;
    localparam logic [MUX_W-1:0]  MUX_ON     = 10'h102;

endpackage

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] cnt_d, cnt_q;

    assign reached = en && (cnt_q == (limit - 1'b1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr || reached) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/seq_rise_detect.sv
module seq_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic d_q;

    assign rise = d && !d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= 1'b0;
        else        d_q <= d;
    end
endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int BANKS         = 20,
    parameter int CYC_PER_US    = 50,
    parameter int HS_RETRIES    = 10,
    parameter int BANK_DWELL_MS = 10,
    parameter int HANDOVER_MS   = 5000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    ms_tick,
    input  logic                    hs_status,
    input  logic                    handover,
    input  logic [ADDR_W-1:0]       boot_addr,
    output logic                    subsys_rst,
    output logic                    core_blk_rst,
    output logic [4:0]              glb_cfg0,
    output logic                    glb_cfg1_b0,
    output logic [ADDR_W-5:0]       vec_base,
    output logic                    xo_en,
    output logic [31:0]             pwr_word,
    output logic [BANKS-1:0]        mem_bank_en,
    output logic [2:0]              core_rst_ctl,
    output logic                    dbg_keep,
    output logic [9:0]              clk_mux,
    output logic                    hs_warn,
    output logic                    done,
    output logic                    timeout,
    output logic [4:0]              step
);
    localparam int VEC_W   = ADDR_W - VEC_SHIFT;
    localparam int BIDX_W  = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int MS_A    = (HS_RETRIES > BANK_DWELL_MS) ? HS_RETRIES : BANK_DWELL_MS;
    localparam int MS_MAX  = (MS_A > HANDOVER_MS) ? MS_A : HANDOVER_MS;
    localparam int MS_CW   = $clog2(MS_MAX + 1);
    localparam int US_CW   = $clog2(CYC_PER_US + 1);

    typedef struct packed {
        seq_state_e              st;
        logic                    subsys;
        logic                    core_blk;
        logic [CFG_W-1:0]        cfg0;
        logic                    cfg1;
        logic [VEC_W-1:0]        vec;
        logic                    xo;
        logic [PWR_W-1:0]        pwr;
        logic [BANKS-1:0]        banks;
        logic [BIDX_W-1:0]       bidx;
        logic [CORE_W-1:0]       core;
        logic                    dbg;
        logic [MUX_W-1:0]        mux;
        logic                    warn;
        logic                    done;
        logic                    tmo;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic             us_en, us_reached;
    logic             ms_en, ms_reached;
    logic             step_chg;
    logic             ho_rise;
    logic [MS_CW-1:0] ms_limit;

    // cycle counter for the head-switch settling wait
    seq_tick_counter #(.W(US_CW)) u_us_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_chg),
        .en      (us_en),
        .limit   (US_CW'(CYC_PER_US)),
        .reached (us_reached)
    );

    // millisecond tick counter shared by poll, bank dwell and handover wait
    seq_tick_counter #(.W(MS_CW)) u_ms_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_chg),
        .en      (ms_en),
        .limit   (ms_limit),
        .reached (ms_reached)
    );

    seq_rise_detect u_ho_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (handover),
        .rise  (ho_rise)
    );

    assign us_en    = (r_q.st == ST_HS);
    assign ms_en    = ms_tick && ((r_q.st == ST_POLL) || (r_q.st == ST_BANK) || (r_q.st == ST_HO));
    assign step_chg = (r_d.st != r_q.st);

    always_comb begin
        case (r_q.st)
            ST_POLL: ms_limit = MS_CW'(HS_RETRIES);
            ST_BANK: ms_limit = MS_CW'(BANK_DWELL_MS);
            default: ms_limit = MS_CW'(HANDOVER_MS);
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.subsys   = 1'b0;
                    r_d.core_blk = 1'b0;
                    r_d.st       = ST_RST;
                end
            end
            ST_RST: begin
                r_d.cfg0 = CFG0_VAL;
                r_d.cfg1 = 1'b0;
                r_d.st   = ST_CFG;
            end
            ST_CFG: begin
                r_d.vec = boot_addr[ADDR_W-1:VEC_SHIFT];
                r_d.st  = ST_VEC;
            end
            ST_VEC: begin
                r_d.xo = 1'b1;
                r_d.st = ST_XO;
            end
            ST_XO: begin
                r_d.pwr = PW_HS_ON;
                r_d.st  = ST_HS;
            end
            ST_HS: begin
                if (us_reached) r_d.st = ST_POLL;
            end
            ST_POLL: begin
                if (hs_status) begin
                    r_d.pwr = PW_BYPASS;
                    r_d.st  = ST_BYP;
                end else if (ms_reached) begin
                    r_d.warn = 1'b1;
                    r_d.pwr  = PW_BYPASS;
                    r_d.st   = ST_BYP;
                end
            end
            ST_BYP: begin
                r_d.pwr = PW_CLAMP;
                r_d.st  = ST_CLAMP;
            end
            ST_CLAMP: begin
                r_d.pwr = PW_SLEEP;
                r_d.st  = ST_SLEEP;
            end
            ST_SLEEP: begin
                r_d.banks[BANKS-1] = 1'b1;
                r_d.bidx           = BIDX_W'(BANKS - 1);
                r_d.st             = ST_BANK;
            end
            ST_BANK: begin
                if (ms_reached) begin
                    if (r_q.bidx == '0) begin
                        r_d.pwr = PW_WLINE;
                        r_d.st  = ST_WL;
                    end else begin
                        r_d.bidx                    = r_q.bidx - 1'b1;
                        r_d.banks[r_q.bidx - 1'b1]  = 1'b1;
                    end
                end
            end
            ST_WL: begin
                r_d.pwr = PW_IO;
                r_d.st  = ST_IO;
            end
            ST_IO: begin
                r_d.core = CORE_HOLD;
                r_d.dbg  = 1'b0;
                r_d.st   = ST_HOLD;
            end
            ST_HOLD: begin
                r_d.mux = MUX_ON;
                r_d.st  = ST_CLK;
            end
            ST_CLK: begin
                r_d.core = CORE_GO;
                r_d.st   = ST_HO;
            end
            ST_HO: begin
                if (ho_rise) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_RUN;
                end else if (ms_reached) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = ST_FAIL;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.subsys   <= 1'b1;
            r_q.core_blk <= 1'b1;
            r_q.cfg0     <= '0;
            r_q.cfg1     <= 1'b1;
            r_q.vec      <= '0;
            r_q.xo       <= 1'b0;
            r_q.pwr      <= '0;
            r_q.banks    <= '0;
            r_q.bidx     <= '0;
            r_q.core     <= CORE_RESET;
            r_q.dbg      <= 1'b1;
            r_q.mux      <= '0;
            r_q.warn     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.tmo      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign subsys_rst   = r_q.subsys;
    assign core_blk_rst = r_q.core_blk;
    assign glb_cfg0     = r_q.cfg0;
    assign glb_cfg1_b0  = r_q.cfg1;
    assign vec_base     = r_q.vec;
    assign xo_en        = r_q.xo;
    assign pwr_word     = r_q.pwr;
    assign mem_bank_en  = r_q.banks;
    assign core_rst_ctl = r_q.core;
    assign dbg_keep     = r_q.dbg;
    assign clk_mux      = r_q.mux;
    assign hs_warn      = r_q.warn;
    assign done         = r_q.done;
    assign timeout      = r_q.tmo;
    assign step         = r_q.st;

endmodule

// File: rtl/dsp_boot_seq_chk.sv
module dsp_boot_seq_chk #(
    parameter int BANKS = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      pwr_word,
    input logic [BANKS-1:0] mem_bank_en,
    input logic [2:0]       core_rst_ctl,
    input logic [9:0]       clk_mux,
    input logic             done,
    input logic             timeout,
    input logic [4:0]       step
);
    // R1: idle keeps the power word cleared
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 5'd0) |-> (pwr_word == 32'h0));

    // R2: start outside idle never restarts the sequence
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && step != 5'd0) |=> (step != 5'd1));

    // R6: the power word does not move during the bank phase
    p_pwr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 5'd10 && $past(step) == 5'd10) |-> $stable(pwr_word));

    // R7: banks change one bit at a time and never turn off
    p_bank_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_bank_en != $past(mem_bank_en)) |->
        (($countones(mem_bank_en ^ $past(mem_bank_en)) == 1) &&
         ((mem_bank_en & $past(mem_bank_en)) == $past(mem_bank_en))));

    // R8: a running core has its clock on and reset released
    p_run_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (core_rst_ctl == 3'h4 && clk_mux == 10'h102));

    // R9: done only rises out of the handover wait
    p_done_from_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(step) == 5'd15));

    // R10: done and timeout are exclusive, timeout persists
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
    p_tmo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);
endmodule

bind dsp_boot_seq dsp_boot_seq_chk #(.BANKS(BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .pwr_word     (pwr_word),
    .mem_bank_en  (mem_bank_en),
    .core_rst_ctl (core_rst_ctl),
    .clk_mux      (clk_mux),
    .done         (done),
    .timeout      (timeout),
    .step         (step)
);

// File: tb/sim_dsp_boot_seq.sv
module sim_dsp_boot_seq;
    localparam int NB    = 20;
    localparam int CYC   = 50;
    localparam int HOMS  = 5000;
    localparam int NVEC  = 4;

    // [63:32] boot address, [31:24] status mode, [23:8] handover delay (0 = none),
    // [1] expected warn, [0] expected timeout
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h4A40_0000, 8'd0, 16'd7, 8'b00},
        {32'h1234_5678, 8'd1, 16'd1, 8'b10},
        {32'hFFFF_FFF0, 8'd0, 16'd0, 8'b01},
        {32'h0000_0010, 8'd2, 16'd3, 8'b00}
    };

    localparam logic [31:0] PSEQ [7] = '{32'h0, 32'h0170_0000, 32'h0370_0000,
        32'h0330_0000, 32'h033C_0000, 32'h031F_FFFF, 32'h030F_FFFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic        hs_status = 1'b0;
    logic        handover = 1'b0;
    logic [31:0] boot_addr = '0;
    logic        subsys_rst, core_blk_rst, glb_cfg1_b0, xo_en, dbg_keep;
    logic        hs_warn, done, timeout;
    logic [4:0]  glb_cfg0, step;
    logic [27:0] vec_base;
    logic [31:0] pwr_word;
    logic [NB-1:0] mem_bank_en;
    logic [2:0]  core_rst_ctl;
    logic [9:0]  clk_mux;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int cur_mode = 0;

    always #10 clk = ~clk;

    dsp_boot_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .hs_status(hs_status), .handover(handover), .boot_addr(boot_addr),
        .subsys_rst(subsys_rst), .core_blk_rst(core_blk_rst),
        .glb_cfg0(glb_cfg0), .glb_cfg1_b0(glb_cfg1_b0), .vec_base(vec_base),
        .xo_en(xo_en), .pwr_word(pwr_word), .mem_bank_en(mem_bank_en),
        .core_rst_ctl(core_rst_ctl), .dbg_keep(dbg_keep), .clk_mux(clk_mux),
        .hs_warn(hs_warn), .done(done), .timeout(timeout), .step(step)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<200000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // monitor and input timebase, all on the falling edge
    logic [31:0]   p_pwr;
    logic [NB-1:0] p_banks;
    logic [27:0]   p_vec;
    logic [2:0]    p_core;
    logic [4:0]    p_step;
    logic          p_tmo;
    int pidx, bank_n, tick_acc, poll_ticks, hs_cycles, ho_ticks, tdiv;
    initial begin
        pidx = 0; bank_n = 0; tick_acc = 0; poll_ticks = 0;
        hs_cycles = 0; ho_ticks = 0; tdiv = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            pidx = 0; bank_n = 0; tick_acc = 0; poll_ticks = 0;
            hs_cycles = 0; ho_ticks = 0;
        end else begin
            if (ms_tick && p_step == 5'd10) tick_acc++;
            if (ms_tick && p_step == 5'd6)  poll_ticks++;
            if (ms_tick && p_step == 5'd15) ho_ticks++;
            if (pwr_word == 32'h0170_0000) hs_cycles++;
            if (pwr_word != p_pwr) begin
                if (pidx < 6) chk(pwr_word == PSEQ[pidx+1], "R6 power word order", pwr_word, PSEQ[pidx+1]);
                else chk(1'b0, "R6 extra power word", pwr_word, p_pwr);
                if (pwr_word == 32'h0170_0000) chk(xo_en, "R3 crystal before head switch", xo_en, 1);
                if (pwr_word == 32'h0370_0000) begin
                    if (cur_mode == 0) chk(hs_cycles == CYC + 1, "R4 head-switch settle cycles", hs_cycles, CYC + 1);
                    if (cur_mode == 1) chk(poll_ticks == 10, "R5 poll retry ticks", poll_ticks, 10);
                    if (cur_mode == 2) chk(poll_ticks == 3, "R5 late status ticks", poll_ticks, 3);
                end
                if (pwr_word == 32'h031F_FFFF) begin
                    chk(tick_acc == 10, "R7 last bank dwell", tick_acc, 10);
                    chk(mem_bank_en == '1, "R7 all banks on", mem_bank_en, {NB{1'b1}});
                end
                pidx++;
            end
            if (mem_bank_en != p_banks) begin
                chk(mem_bank_en == (p_banks | (NB'(1) << (NB - 1 - bank_n))), "R7 bank order",
                    mem_bank_en, p_banks | (NB'(1) << (NB - 1 - bank_n)));
                if (bank_n > 0) chk(tick_acc == 10, "R7 bank dwell", tick_acc, 10);
                tick_acc = 0;
                bank_n++;
            end
            if (vec_base != p_vec)
                chk(glb_cfg0 == 5'h14 && !glb_cfg1_b0 && !subsys_rst && !core_blk_rst,
                    "R3 config and resets before vector", {glb_cfg0, glb_cfg1_b0, subsys_rst, core_blk_rst}, {5'h14, 3'b000});
            if (core_rst_ctl != p_core) begin
                if (core_rst_ctl == 3'h5) chk(clk_mux == 0 && dbg_keep == 0, "R8 hold phase", {clk_mux, dbg_keep}, 0);
                else if (core_rst_ctl == 3'h4) chk(clk_mux == 10'h102, "R8 clock before run", clk_mux, 10'h102);
                else chk(1'b0, "R8 reset value", core_rst_ctl, 3'h5);
            end
            if (timeout && !p_tmo) chk(ho_ticks == HOMS, "R10 handover window ticks", ho_ticks, HOMS);
        end
        p_pwr = pwr_word; p_banks = mem_bank_en; p_vec = vec_base;
        p_core = core_rst_ctl; p_step = step; p_tmo = timeout;
        case (cur_mode)
            0: hs_status = 1'b1;
            1: hs_status = 1'b0;
            default: hs_status = (poll_ticks >= 3);
        endcase
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        ms_tick = (tdiv == 2);
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; handover = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_step(input logic [4:0] s);
        for (int i = 0; i < 30000 && step != s; i++) @(negedge clk);
    endtask

    initial begin
        // reset state
        do_reset();
        @(negedge clk);
        chk(subsys_rst && core_blk_rst && glb_cfg0 == 0 && glb_cfg1_b0 && vec_base == 0 && !xo_en,
            "R1 idle controls", {subsys_rst, core_blk_rst, glb_cfg0, glb_cfg1_b0, xo_en}, 9'b110000010);
        chk(pwr_word == 0 && mem_bank_en == 0 && core_rst_ctl == 3'h1 && dbg_keep && clk_mux == 0,
            "R1 idle power and core", {pwr_word, core_rst_ctl}, 35'h1);
        chk(!hs_warn && !done && !timeout && step == 0, "R1 idle flags R11", {hs_warn, done, timeout, step}, 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            cur_mode = int'(VECS[v][31:24]);
            boot_addr = VECS[v][63:32];
            do_reset();
            pulse_start();
            chk(step != 0, "R3 sequence started", step, 1);
            wait_step(5'd6);
            chk(step == 5'd6, "R11 poll step", step, 6);
            wait_step(5'd15);
            chk(step == 5'd15, "R11 handover wait step", step, 15);
            if (VECS[v][23:8] != 0) begin
                repeat (3 * int'(VECS[v][23:8])) @(negedge clk);
                handover = 1'b1;
                @(negedge clk);
                chk(done && step == 5'd16, "R9 done after rising edge", {done, step}, {1'b1, 5'd16});
            end else begin
                wait_step(5'd17);
            end
            chk(timeout == VECS[v][0], "R10 timeout flag", timeout, VECS[v][0]);
            chk(done == !VECS[v][0], "R9 done flag", done, !VECS[v][0]);
            chk(hs_warn == VECS[v][1], "R5 warn flag", hs_warn, VECS[v][1]);
            chk(vec_base == VECS[v][63:36], "R3 vector value", vec_base, VECS[v][63:36]);
            chk(pwr_word == 32'h030F_FFFF && mem_bank_en == '1, "R6 final power", pwr_word, 32'h030F_FFFF);
            chk(core_rst_ctl == 3'h4 && clk_mux == 10'h102 && !dbg_keep, "R8 final core", {core_rst_ctl, clk_mux}, {3'h4, 10'h102});
            handover = 1'b0;
        end

        // start during the bank phase is ignored
        cur_mode = 0;
        boot_addr = 32'h0000_1230;
        do_reset();
        pulse_start();
        wait_step(5'd10);
        begin
            logic [31:0] pw;
            pw = pwr_word;
            pulse_start();
            chk(step == 5'd10 && pwr_word == pw, "R2 start ignored while busy", {step, pwr_word}, {5'd10, pw});
        end
        wait_step(5'd15);
        @(negedge clk); handover = 1'b1;
        @(negedge clk);
        chk(done, "R9 done in directed run", done, 1);
        // start after running is ignored
        pulse_start();
        @(negedge clk);
        chk(step == 5'd16 && done && pwr_word == 32'h030F_FFFF, "R2 start ignored when running", step, 16);
        handover = 1'b0;

        // handover already high before the wait does not count
        do_reset();
        handover = 1'b1;
        pulse_start();
        wait_step(5'd17);
        chk(timeout && !done && step == 5'd17, "R9 held level ignored R10", {timeout, done, step}, {1'b1, 1'b0, 5'd17});
        handover = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule